// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Flags

This block is one bank of general-purpose pins. Software sees it as a small register file on a single-cycle memory-mapped bus with address, write enable, write data and read data. The read path is combinational. Each implemented pin can be a plain input, a plain output, one of three alternate-function selections, or an interrupt source. In interrupt mode a pin is sensitive to a rising edge, a falling edge, a high level or a low level. Every pin has a sticky flag, and any flag that is not masked raises the single bank interrupt output.

Three per-pin configuration bits (function, select, trigger) pick the mode, and the direction bit refines it. The decoded per-pin modes are GPIO_IN, GPIO_OUT, ALT1, ALT2, ALT3, IRQ_EDGE and IRQ_LEVEL. A pin moves between these modes only when software writes a configuration bit, and the move takes effect on the clock edge of that write. Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier. Each writable register also has a set alias and a clear alias, so that software can change individual bits without a read-modify-write.

Top module: `gib_bank`

## Requirements
- R1: After reset the mask register reads all ones on implemented bits. Every other register and every flag reads 0, `irq` is 0, `pin_oe` is 0 and `pin_pu_en` is all ones.
- R2: Register groups are decoded from address bits [7:4]: live level 0x00, data 0x10, mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60, trigger 0x70, flag 0x80. A write at a group base replaces the register. A read at any offset in a group returns that group's register, and addresses above 0x8F read 0.
- R3: A write at base+4 sets only the bits written as 1. A write at base+8 clears only the bits written as 1. All other bits keep their value.
- R4: A read at 0x00 returns each pin's level as it was two clock edges earlier (two-flop synchroniser), in every mode.
- R5: With function=0 and select=0, `pin_oe` equals the direction bit (1 = GPIO_OUT, 0 = GPIO_IN). `pin_do` always follows the data register.
- R6: With function=1, `pin_oe` is 0. The 2-bit field `pin_alt[2i+1:2i]` reads 1 when select=0, 2 when select=1 and trigger=0, and 3 when select=1 and trigger=1. In all other modes the field reads 0.
- R7: With function=0, select=1 and trigger=1 (IRQ_EDGE), the flag sets one cycle after a synchronised edge. Direction=1 selects rising edges and direction=0 selects falling edges.
- R8: With function=0, select=1 and trigger=0 (IRQ_LEVEL), the flag sets in any cycle where the synchronised level equals the direction bit.
- R9: A flag stays set until a 1 is written to its bit at 0x88. If the pin's condition still holds in that cycle, the flag stays set. Writes at 0x80, 0x84 and 0x8C have no effect on the flags.
- R10: `irq` is 1 exactly when some flag is set whose mask bit is 0. A mask bit of 1 does not stop its flag from latching.
- R11: `pin_pu_en` is the inverse of the pull register (pull bit 1 disables the pull-up).
- R12: With NPINS below 32, bits at and above NPINS read 0 in every register and cannot be written.
- R13: Pins in GPIO or alternate-function modes never set their flags, whatever their input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | NPINS | Raw pin levels |
| pin_oe | output | NPINS | Output enable for GPIO_OUT pins |
| pin_do | output | NPINS | Output data (data register) |
| pin_pu_en | output | NPINS | Pull-up enable |
| pin_alt | output | 2*NPINS | Alternate-function number per pin, 0 = none |
| irq | output | 1 | Bank interrupt |

## Verification
A wrong configuration bit shows up on `pin_oe`, `pin_alt` or `pin_pu_en` in the cycle after the write. A wrong synchroniser or edge-history stage moves the level read at 0x00, and the flag set, by one or more cycles; the effect appears two to three cycles after the pin changes. A wrong flag or mask state shows up on `irq` and in the flag read on the very next cycle. The bench therefore compares every output with a behavioural model on every clock, so any of these faults is caught within three cycles of its cause.

// File: rtl/gib_pkg.sv
package gib_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam int GRP_LEVEL = 0;
    localparam int GRP_DATA  = 1;
    localparam int GRP_MASK  = 2;
    localparam int GRP_PULL  = 3;
    localparam int GRP_FUNC  = 4;
    localparam int GRP_SEL   = 5;
    localparam int GRP_DIR   = 6;
    localparam int GRP_TRIG  = 7;
    localparam int GRP_FLAG  = 8;
    localparam int GRP_LAST_RW = 7;

    typedef enum logic [1:0] {
        AC_WRITE = 2'd0,
        AC_SET   = 2'd1,
        AC_CLEAR = 2'd2,
        AC_NONE  = 2'd3
    } access_e;

    typedef enum logic [2:0] {
        PM_GPIO_IN,
        PM_GPIO_OUT,
        PM_ALT1,
        PM_ALT2,
        PM_ALT3,
        PM_IRQ_EDGE,
        PM_IRQ_LEVEL
    } pin_mode_e;

    function automatic pin_mode_e decode_mode(input logic func, input logic sel,
                                              input logic trig, input logic dir);
        pin_mode_e m;
        unique case ({func, sel})
            2'b00:   m = dir  ? PM_GPIO_OUT : PM_GPIO_IN;
            2'b01:   m = trig ? PM_IRQ_EDGE : PM_IRQ_LEVEL;
            2'b10:   m = PM_ALT1;
            default: m = trig ? PM_ALT3 : PM_ALT2;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gib_reg_group.sv
module gib_reg_group
    import gib_pkg::*;
#(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  access_e      acc_i,
    input  logic [W-1:0] wd_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= RST;
        end else if (hit_i) begin
            unique case (acc_i)
                AC_WRITE: q_o <= wd_i;
                AC_SET:   q_o <= q_o | wd_i;
                AC_CLEAR: q_o <= q_o & ~wd_i;
                default:  q_o <= q_o;
            endcase
        end
    end

endmodule

// File: rtl/gib_pin_cell.sv
module gib_pin_cell
    import gib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       func_b,
    input  logic       sel_b,
    input  logic       trig_b,
    input  logic       dir_b,
    input  logic       flag_clr_b,
    output logic       lvl_o,
    output logic       oe_o,
    output logic [1:0] alt_o,
    output logic       flag_o
);

    logic      sync1, sync2, sync_prev;
    logic      cond_hit;
    pin_mode_e mode;

    assign mode  = decode_mode(func_b, sel_b, trig_b, dir_b);
    assign lvl_o = sync2;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1     <= 1'b0;
            sync2     <= 1'b0;
            sync_prev <= 1'b0;
            flag_o    <= 1'b0;
        end else begin
            sync1     <= pin_i;
            sync2     <= sync1;
            sync_prev <= sync2;
            if (cond_hit)        flag_o <= 1'b1;
            else if (flag_clr_b) flag_o <= 1'b0;
        end
    end

    // output process
    always_comb begin
        cond_hit = 1'b0;
        oe_o     = 1'b0;
        alt_o    = 2'd0;
        unique case (mode)
            PM_GPIO_IN:   ;
            PM_GPIO_OUT:  oe_o = 1'b1;
            PM_ALT1:      alt_o = 2'd1;
            PM_ALT2:      alt_o = 2'd2;
            PM_ALT3:      alt_o = 2'd3;
            PM_IRQ_EDGE:  cond_hit = dir_b ? (sync2 & ~sync_prev) : (~sync2 & sync_prev);
            PM_IRQ_LEVEL: cond_hit = (sync2 == dir_b);
            default:      ;
        endcase
    end

endmodule

// File: rtl/gib_bank.sv
module gib_bank
    import gib_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_oe,
    output logic [NPINS-1:0]    pin_do,
    output logic [NPINS-1:0]    pin_pu_en,
    output logic [2*NPINS-1:0]  pin_alt,
    output logic                irq
);

    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

    logic [3:0]       wr_grp;
    access_e          wr_acc;
    logic [NPINS-1:0] grp_q [1:GRP_LAST_RW];
    logic [NPINS-1:0] lvl_q, flag_q, flag_clr;
    logic [NPINS-1:0] mask_q, sel_q;
    logic             unused_addr_bits;

    assign wr_grp           = bus_addr[7:4];
    assign unused_addr_bits = ^bus_addr[1:0];

    always_comb begin
        unique case (bus_addr[3:2])
            2'd0:    wr_acc = AC_WRITE;
            2'd1:    wr_acc = AC_SET;
            2'd2:    wr_acc = AC_CLEAR;
            default: wr_acc = AC_NONE;
        endcase
    end

    for (genvar g = 1; g <= GRP_LAST_RW; g++) begin : g_grp
        localparam logic [NPINS-1:0] RV = (g == GRP_MASK) ? ALL_ONES : '0;
        gib_reg_group #(.W(NPINS), .RST(RV)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .hit_i (bus_we && (wr_grp == 4'(g))),
            .acc_i (wr_acc),
            .wd_i  (bus_wdata[NPINS-1:0]),
            .q_o   (grp_q[g])
        );
    end

    assign flag_clr = (bus_we && wr_grp == 4'(GRP_FLAG) && wr_acc == AC_CLEAR)
                      ? bus_wdata[NPINS-1:0] : '0;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gib_pin_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (pin_in[i]),
            .func_b     (grp_q[GRP_FUNC][i]),
            .sel_b      (grp_q[GRP_SEL][i]),
            .trig_b     (grp_q[GRP_TRIG][i]),
            .dir_b      (grp_q[GRP_DIR][i]),
            .flag_clr_b (flag_clr[i]),
            .lvl_o      (lvl_q[i]),
            .oe_o       (pin_oe[i]),
            .alt_o      (pin_alt[2*i +: 2]),
            .flag_o     (flag_q[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (wr_grp)
            4'(GRP_LEVEL): bus_rdata[NPINS-1:0] = lvl_q;
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7:
                           bus_rdata[NPINS-1:0] = grp_q[wr_grp[2:0]];
            4'(GRP_FLAG):  bus_rdata[NPINS-1:0] = flag_q;
            default:       ;
        endcase
    end

    assign mask_q    = grp_q[GRP_MASK];
    assign sel_q     = grp_q[GRP_SEL];
    assign pin_do    = grp_q[GRP_DATA];
    assign pin_pu_en = ~grp_q[GRP_PULL];
    assign irq       = |(flag_q & ~mask_q);

endmodule

// File: rtl/gib_bank_chk.sv
module gib_bank_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input logic [NPINS-1:0] flag_vec,
    input logic [NPINS-1:0] mask_vec,
    input logic [NPINS-1:0] sel_vec
);

    localparam logic [31:0] IMPL = 32'hFFFF_FFFF >> (32 - NPINS);

    AST_SET_ALIAS_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h54) |=>
            ((sel_vec & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])) &&
            ((sel_vec & ~$past(bus_wdata[NPINS-1:0])) == ($past(sel_vec) & ~$past(bus_wdata[NPINS-1:0])))); // R3

    AST_CLEAR_ALIAS_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h28) |=>
            ((mask_vec & $past(bus_wdata[NPINS-1:0])) == '0) &&
            ((mask_vec & ~$past(bus_wdata[NPINS-1:0])) == ($past(mask_vec) & ~$past(bus_wdata[NPINS-1:0])))); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 8'h88) |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec))); // R9

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (((flag_vec & ~$past(flag_vec)) != '0) ||
                        ((~mask_vec & $past(mask_vec)) != '0))); // R10

    AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~IMPL) == 32'h0)); // R12

endmodule

bind gib_bank gib_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .flag_vec  (flag_q),
    .mask_vec  (mask_q),
    .sel_vec   (sel_q)
);

// File: tb/sim_gib_bank.sv
`timescale 1ns/1ps
module sim_gib_bank;

    localparam int NP = 31;
    localparam logic [31:0] IM = 32'hFFFF_FFFF >> (32 - NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe, pin_do, pin_pu_en;
    logic [2*NP-1:0] pin_alt;
    logic          irq;

    int    vec = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    gib_bank #(.NPINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_do(pin_do), .pin_pu_en(pin_pu_en),
        .pin_alt(pin_alt), .irq(irq)
    );

    // behavioural reference model: m_reg[g] is register group g, m_reg[8] the flags
    logic [31:0] m_reg [0:8] = '{default: 32'h0};
    logic [31:0] m_s1 = 0, m_s2 = 0, m_s3 = 0;
    logic [31:0] t_hit, t_nf;
    int          t_g, t_o;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= 8; k++) m_reg[k] = 32'h0;
            m_reg[2] = IM;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            t_hit = 0;
            for (int i = 0; i < NP; i++) begin
                if (!m_reg[4][i] && m_reg[5][i]) begin
                    if (m_reg[7][i])
                        t_hit[i] = m_reg[6][i] ? (m_s2[i] && !m_s3[i]) : (!m_s2[i] && m_s3[i]);
                    else
                        t_hit[i] = (m_s2[i] == m_reg[6][i]);
                end
            end
            t_g = int'(bus_addr) / 16;
            t_o = (int'(bus_addr) / 4) % 4;
            t_nf = m_reg[8];
            if (bus_we && t_g == 8 && t_o == 2) t_nf = t_nf & ~bus_wdata;
            t_nf = (t_nf | t_hit) & IM;
            if (bus_we && t_g >= 1 && t_g <= 7) begin
                if (t_o == 0)      m_reg[t_g] = bus_wdata & IM;
                else if (t_o == 1) m_reg[t_g] = (m_reg[t_g] | bus_wdata) & IM;
                else if (t_o == 2) m_reg[t_g] = m_reg[t_g] & ~bus_wdata;
            end
            m_reg[8] = t_nf;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = 32'(pin_in);
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int g = int'(a) / 16;
        if (g == 0) return m_s2;
        if (g <= 8) return m_reg[g];
        return 32'h0;
    endfunction

    function automatic logic [63:0] exp_alt();
        logic [63:0] r = 0;
        for (int i = 0; i < NP; i++) begin
            if (m_reg[4][i]) r[2*i +: 2] = !m_reg[5][i] ? 2'd1 : (m_reg[7][i] ? 2'd3 : 2'd2);
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_oe();
        return ~m_reg[4] & ~m_reg[5] & m_reg[6] & IM;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        check(cur_req, "rdata",  64'(bus_rdata), 64'(exp_rd(bus_addr)));
        check(cur_req, "oe",     64'(pin_oe), 64'(exp_oe()));
        check(cur_req, "do",     64'(pin_do), 64'(m_reg[1]));
        check(cur_req, "pu_en",  64'(pin_pu_en), 64'(~m_reg[3] & IM));
        check(cur_req, "alt",    64'(pin_alt), exp_alt());
        check(cur_req, "irq",    64'(irq), 64'(|(m_reg[8] & ~m_reg[2])));
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            cmp_all();
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        cyc(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] e);
        bus_addr = a;
        #0.5;
        check(req, "read", 64'(bus_rdata), 64'(e));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1);

        cur_req = "R1";
        rd("R1", 8'h20, IM);
        rd("R1", 8'h10, 32'h0);
        rd("R1", 8'h80, 32'h0);
        check("R1", "pu_en", 64'(pin_pu_en), 64'(IM));
        check("R1", "irq", 64'(irq), 64'h0);

        cur_req = "R2";
        wr(8'h10, 32'h1234_5678);
        rd("R2", 8'h10, 32'h1234_5678);
        rd("R2", 8'h14, 32'h1234_5678);
        rd("R2", 8'h90, 32'h0);

        cur_req = "R3";
        wr(8'h14, 32'h0000_0F00);
        rd("R3", 8'h10, 32'h1234_5F78);
        wr(8'h18, 32'h0000_0078);
        rd("R3", 8'h10, 32'h1234_5F00);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd("R3", 8'h10, 32'h1234_5F00);

        cur_req = "R12";
        wr(8'h30, 32'hFFFF_FFFF);
        rd("R12", 8'h30, 32'h7FFF_FFFF);
        check("R11", "pu_en", 64'(pin_pu_en), 64'h0);
        cur_req = "R11";
        wr(8'h38, 32'h0000_0001);
        check("R11", "pu_en", 64'(pin_pu_en), 64'h1);

        cur_req = "R5";
        wr(8'h60, 32'h0000_00FF);
        check("R5", "oe", 64'(pin_oe), 64'hFF);
        check("R5", "do", 64'(pin_do), 64'h1234_5F00);

        cur_req = "R6";
        wr(8'h74, 32'h0000_0004);
        wr(8'h54, 32'h0000_0006);
        wr(8'h44, 32'h0000_0007);
        check("R6", "oe", 64'(pin_oe), 64'hF8);
        check("R6", "alt", 64'(pin_alt), 64'h39);

        cur_req = "R4";
        pin_in = 31'h5555_0007;
        cyc(1);
        rd("R4", 8'h00, 32'h0);
        cyc(1);
        rd("R4", 8'h00, 32'h5555_0007);
        pin_in = '0;
        cyc(4);
        rd("R13", 8'h80, 32'h0);

        cur_req = "R7";
        wr(8'h74, 32'h0003_0000);
        wr(8'h64, 32'h0001_0000);
        wr(8'h54, 32'h0003_0000);
        wr(8'h28, 32'h0003_0000);
        cyc(3);
        rd("R7", 8'h80, 32'h0);
        pin_in[16] = 1'b1;
        cyc(3);
        rd("R7", 8'h80, 32'h0001_0000);
        check("R7", "irq", 64'(irq), 64'h1);
        wr(8'h88, 32'h0001_0000);
        rd("R9", 8'h80, 32'h0);
        pin_in[17] = 1'b1;
        cyc(4);
        rd("R7", 8'h80, 32'h0);
        pin_in[17] = 1'b0;
        cyc(4);
        rd("R7", 8'h80, 32'h0002_0000);
        wr(8'h88, 32'h0002_0000);

        cur_req = "R10";
        wr(8'h24, 32'h0002_0000);
        pin_in[17] = 1'b1;
        cyc(3);
        pin_in[17] = 1'b0;
        cyc(4);
        rd("R10", 8'h80, 32'h0002_0000);
        check("R10", "irq", 64'(irq), 64'h0);
        wr(8'h28, 32'h0002_0000);
        check("R10", "irq", 64'(irq), 64'h1);
        wr(8'h88, 32'h0002_0000);
        check("R10", "irq", 64'(irq), 64'h0);

        cur_req = "R8";
        wr(8'h64, 32'h0010_0000);
        wr(8'h54, 32'h0030_0000);
        cyc(1);
        rd("R8", 8'h80, 32'h0020_0000);
        wr(8'h88, 32'h0020_0000);
        rd("R9", 8'h80, 32'h0020_0000);
        pin_in[21] = 1'b1;
        cyc(3);
        wr(8'h88, 32'h0020_0000);
        rd("R8", 8'h80, 32'h0);
        pin_in[20] = 1'b1;
        cyc(3);
        rd("R8", 8'h80, 32'h0010_0000);

        cur_req = "R9";
        pin_in[20] = 1'b0;
        cyc(4);
        rd("R9", 8'h80, 32'h0010_0000);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h8C, 32'hFFFF_FFFF);
        rd("R9", 8'h80, 32'h0010_0000);
        wr(8'h88, 32'h0010_0000);
        rd("R9", 8'h80, 32'h0);
        cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule